// File: doc/BRIEF.md
# Boot-Block Address Decoder with Write Protection

This block sits beside a boot-block flash array and decodes each double-word address into a block number. It reports whether the block is one of the small parameter blocks or one of the large main blocks. For program and erase requests it also decides whether the operation may proceed. The array holds 39 blocks: eight parameter blocks of 2048 words each and thirty-one main blocks of 16384 words each. Together they cover a 19-bit word address space.

A build-time parameter places the parameter region at either end of the space. Block numbers always rise with address. Each block has a lock bit. All lock bits are set by reset. A one-cycle strobe carrying a block number sets or clears a single lock bit. A write-protect input guards every main block and the two parameter blocks at the outer end of the space. A request is accepted for one cycle, and the answer appears registered on the next cycle.

Top module: `bbp_boot_map`

## Requirements
- R1: With PARAM_AT_TOP=0, an address whose bits [18:14] are zero is a parameter block with number addr[18:11]. Any other address is a main block with number 7 + addr[18:14].
- R2: With PARAM_AT_TOP=1, an address whose bits [18:14] are all ones is a parameter block with number 31 + addr[13:11]. Any other address is a main block with number addr[18:14].
- R3: A request with req_valid high gives rsp_valid high on the next cycle. That response carries the decoded block number and region flag.
- R4: After reset every block is locked. A program or erase to any block then raises rsp_violation and leaves rsp_allowed low.
- R5: lock_clr clears the lock bit of block lock_idx, and lock_set sets it. When both strobes arrive together, set wins. A request issued after the strobe cycle sees the new value.
- R6: While wp_active is high, program and erase are refused on every main block and on the two outermost parameter blocks: blocks 0 and 1 when PARAM_AT_TOP=0, blocks 37 and 38 when PARAM_AT_TOP=1. The other parameter blocks are unaffected by wp_active.
- R7: Ops are encoded as 0 idle, 1 read, 2 program, 3 erase. For idle or read, rsp_allowed and rsp_violation both stay low, whatever the lock and protect state.
- R8: A cycle without a request gives rsp_valid and rsp_violation low on the next cycle, so a violation is a single-cycle pulse.
- R9: A lock strobe whose lock_idx is 39 or above changes no lock bit.
- R10: While rst is high, no response is produced and lock strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the device is write-protected while it is high |
| wp_active | input | 1 | Write-protect request, high to protect the covered blocks |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 19 | Double-word address |
| req_op | input | 2 | Operation: 0 idle, 1 read, 2 program, 3 erase |
| lock_set | input | 1 | Set the lock bit of lock_idx |
| lock_clr | input | 1 | Clear the lock bit of lock_idx |
| lock_idx | input | 6 | Block number for lock strobes |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_block | output | 6 | Decoded block number |
| rsp_is_param | output | 1 | High for a parameter block |
| rsp_allowed | output | 1 | Program or erase permitted |
| rsp_violation | output | 1 | Program or erase refused, one-cycle pulse |

## Verification
Every response field is due exactly one clock edge after the request edge. The bench therefore drives on the falling edge, queues the expected result at once, and samples 2 ns after the next rising edge, where the monitor pops the queue. A lock strobe acts on the edge that ends its cycle. Each lock change is given its own cycle, and the request that probes it comes on a later cycle, so the bench model and the design agree on the lock state. Both placements of the parameter region are instantiated side by side and receive the same stimulus. Every idle cycle is checked for a quiet response.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

    localparam int ADDR_W       = 19;
    localparam int PARAM_CNT    = 8;
    localparam int MAIN_CNT     = 31;
    localparam int PARAM_LOG2   = 11;
    localparam int MAIN_LOG2    = 14;
    localparam int WP_PARAM_CNT = 2;
    localparam int BLK_CNT      = PARAM_CNT + MAIN_CNT;
    localparam int IDX_W        = $clog2(BLK_CNT);
    localparam int PARAM_SPAN   = PARAM_CNT << PARAM_LOG2;
    localparam int MAIN_SPAN    = MAIN_CNT << MAIN_LOG2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef logic [IDX_W-1:0] blk_idx_t;

    typedef struct packed {
        blk_idx_t idx;
        logic     is_param;
        logic     wp_cov;
    } blk_info_t;

    typedef struct packed {
        logic     valid;
        blk_idx_t idx;
        logic     is_param;
        logic     allowed;
        logic     violation;
    } rsp_t;

    function automatic logic is_modify(input op_e op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction

    function automatic logic wp_covers(input blk_idx_t idx, input logic is_param,
                                       input bit at_top);
        if (!is_param)
            return 1'b1;
        if (at_top)
            return int'(idx) >= (BLK_CNT - WP_PARAM_CNT);
        return int'(idx) < WP_PARAM_CNT;
    endfunction

endpackage

// File: rtl/bbp_decode.sv
module bbp_decode
    import bbp_pkg::*;
#(
    parameter bit PARAM_AT_TOP = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output blk_info_t         info
);

    logic [ADDR_W-1:0] off;
    blk_idx_t          idx;
    logic              par;

    generate
        if (PARAM_AT_TOP) begin : g_top
            always_comb begin
                if (addr >= ADDR_W'(MAIN_SPAN)) begin
                    par = 1'b1;
                    off = addr - ADDR_W'(MAIN_SPAN);
                    idx = IDX_W'(MAIN_CNT) + IDX_W'(off >> PARAM_LOG2);
                end else begin
                    par = 1'b0;
                    off = addr;
                    idx = IDX_W'(addr >> MAIN_LOG2);
                end
            end
            always_comb begin
                AST_TOP_REGION: assert (par == (int'(idx) >= MAIN_CNT)) else $error("region/index mismatch"); // R2
            end
        end else begin : g_bot
            always_comb begin
                if (addr < ADDR_W'(PARAM_SPAN)) begin
                    par = 1'b1;
                    off = addr;
                    idx = IDX_W'(addr >> PARAM_LOG2);
                end else begin
                    par = 1'b0;
                    off = addr - ADDR_W'(PARAM_SPAN);
                    idx = IDX_W'(PARAM_CNT) + IDX_W'(off >> MAIN_LOG2);
                end
            end
            always_comb begin
                AST_BOT_REGION: assert (par == (int'(idx) < PARAM_CNT)) else $error("region/index mismatch"); // R1
            end
        end
    endgenerate

    always_comb begin
        info.idx      = idx;
        info.is_param = par;
        info.wp_cov   = wp_covers(idx, par, PARAM_AT_TOP);
    end

    always_comb begin
        AST_IDX_RANGE: assert (int'(idx) < BLK_CNT) else $error("block index out of range"); // R1
    end

endmodule

// File: rtl/bbp_lockbank.sv
module bbp_lockbank
    import bbp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  blk_idx_t           idx,
    output logic [BLK_CNT-1:0] locked
);

    genvar g;
    generate
        for (g = 0; g < BLK_CNT; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    locked[g] <= 1'b1;
                else if (set_stb && (int'(idx) == g))
                    locked[g] <= 1'b1;
                else if (clr_stb && (int'(idx) == g))
                    locked[g] <= 1'b0;
            end
        end
    endgenerate

    AST_LOCK_SET: assert property (@(posedge clk) disable iff (rst)
        set_stb && (int'(idx) < BLK_CNT) |=> locked[$past(idx)]) else $error("set failed"); // R5

    AST_LOCK_CLR: assert property (@(posedge clk) disable iff (rst)
        clr_stb && !set_stb && (int'(idx) < BLK_CNT) |=> !locked[$past(idx)]) else $error("clear failed"); // R5

    AST_LOCK_OOR: assert property (@(posedge clk) disable iff (rst)
        (set_stb || clr_stb) && (int'(idx) >= BLK_CNT) |=> $stable(locked)) else $error("out-of-range strobe acted"); // R9

    AST_LOCK_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&locked)) else $error("lock bits not all set after reset"); // R4

endmodule

// File: rtl/bbp_boot_map.sv
module bbp_boot_map
    import bbp_pkg::*;
#(
    parameter bit PARAM_AT_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_active,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    input  logic              lock_set,
    input  logic              lock_clr,
    input  logic [IDX_W-1:0]  lock_idx,
    output logic              rsp_valid,
    output logic [IDX_W-1:0]  rsp_block,
    output logic              rsp_is_param,
    output logic              rsp_allowed,
    output logic              rsp_violation
);

    blk_info_t          dec;
    logic [BLK_CNT-1:0] locked;
    rsp_t               rsp_q;
    op_e                op;
    logic               modify;
    logic               permitted;

    bbp_decode #(.PARAM_AT_TOP(PARAM_AT_TOP)) u_decode (
        .addr (req_addr),
        .info (dec)
    );

    bbp_lockbank u_locks (
        .clk     (clk),
        .rst     (rst),
        .set_stb (lock_set),
        .clr_stb (lock_clr),
        .idx     (lock_idx),
        .locked  (locked)
    );

    always_comb begin
        op        = op_e'(req_op);
        modify    = req_valid && is_modify(op);
        permitted = !locked[dec.idx] && !(wp_active && dec.wp_cov);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid     <= req_valid;
            rsp_q.idx       <= dec.idx;
            rsp_q.is_param  <= dec.is_param;
            rsp_q.allowed   <= modify && permitted;
            rsp_q.violation <= modify && !permitted;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_block     = rsp_q.idx;
    assign rsp_is_param  = rsp_q.is_param;
    assign rsp_allowed   = rsp_q.allowed;
    assign rsp_violation = rsp_q.violation;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("missing response"); // R3

    AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (rst)
        req_valid && is_modify(op) && locked[dec.idx] |=> rsp_violation && !rsp_allowed) else $error("locked block accepted"); // R5

    AST_WP_MAIN: assert property (@(posedge clk) disable iff (rst)
        req_valid && is_modify(op) && wp_active && !dec.is_param |=> rsp_violation) else $error("protected main block accepted"); // R6

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_valid && !is_modify(op) |=> !rsp_allowed && !rsp_violation) else $error("read flagged"); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_violation) else $error("response without request"); // R8

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> !rsp_valid && !rsp_violation) else $error("response during reset"); // R10

endmodule

// File: tb/bbp_boot_map_tb.sv
module bbp_boot_map_tb;
    import bbp_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst = 1'b1;
    logic              wp_active = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_op = 2'd0;
    logic              lock_set = 1'b0;
    logic              lock_clr = 1'b0;
    logic [IDX_W-1:0]  lock_idx = '0;

    logic             b_valid, b_param, b_allow, b_viol;
    logic [IDX_W-1:0] b_blk;
    logic             t_valid, t_param, t_allow, t_viol;
    logic [IDX_W-1:0] t_blk;

    bbp_boot_map #(.PARAM_AT_TOP(1'b0)) u_dut (
        .clk(clk), .rst(rst), .wp_active(wp_active), .req_valid(req_valid),
        .req_addr(req_addr), .req_op(req_op), .lock_set(lock_set), .lock_clr(lock_clr),
        .lock_idx(lock_idx), .rsp_valid(b_valid), .rsp_block(b_blk),
        .rsp_is_param(b_param), .rsp_allowed(b_allow), .rsp_violation(b_viol)
    );

    bbp_boot_map #(.PARAM_AT_TOP(1'b1)) u_dut_top (
        .clk(clk), .rst(rst), .wp_active(wp_active), .req_valid(req_valid),
        .req_addr(req_addr), .req_op(req_op), .lock_set(lock_set), .lock_clr(lock_clr),
        .lock_idx(lock_idx), .rsp_valid(t_valid), .rsp_block(t_blk),
        .rsp_is_param(t_param), .rsp_allowed(t_allow), .rsp_violation(t_viol)
    );

    typedef struct packed {
        logic [7:0] b_idx; logic b_par; logic b_al; logic b_vi;
        logic [7:0] t_idx; logic t_par; logic t_al; logic t_vi;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    lk[BLK_CNT];
    bit    done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic void map_addr(input logic [ADDR_W-1:0] a, input bit top,
                                     output int idx, output bit par);
        int seg;
        int sub;
        seg = int'(a[18:14]);
        sub = int'(a[13:11]);
        if (!top) begin
            par = (seg == 0);
            idx = par ? sub : 7 + seg;
        end else begin
            par = (seg == 31);
            idx = par ? 31 + sub : seg;
        end
    endfunction

    function automatic void judge(input int idx, input bit par, input bit top, input int op,
                                  output bit al, output bit vi);
        bit cov;
        bit mod;
        bit ok;
        cov = !par || (top ? (idx >= 37) : (idx < 2));
        mod = (op == 2) || (op == 3);
        ok  = !lk[idx] && !(wp_active && cov);
        al  = mod && ok;
        vi  = mod && !ok;
    endfunction

    task automatic req(input logic [ADDR_W-1:0] a, input int op, input string tag);
        exp_t e;
        int   bi, ti;
        bit   bp, tp, ba, bv, ta, tv;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_op    = 2'(op);
        map_addr(a, 1'b0, bi, bp);
        map_addr(a, 1'b1, ti, tp);
        judge(bi, bp, 1'b0, op, ba, bv);
        judge(ti, tp, 1'b1, op, ta, tv);
        e = '{b_idx: 8'(bi), b_par: bp, b_al: ba, b_vi: bv,
              t_idx: 8'(ti), t_par: tp, t_al: ta, t_vi: tv};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic lock_op(input bit s, input bit c, input int idx);
        @(negedge clk);
        lock_set = s;
        lock_clr = c;
        lock_idx = IDX_W'(idx);
        if (!rst && idx < BLK_CNT) begin
            if (s) lk[idx] = 1'b1;
            else if (c) lk[idx] = 1'b0;
        end
        @(negedge clk);
        lock_set = 1'b0;
        lock_clr = 1'b0;
    endtask

    // Monitor: sample 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "R3 bottom valid", int'(b_valid), 1);
                chk(t, "bottom block", int'(b_blk), int'(e.b_idx));
                chk(t, "bottom is_param", int'(b_param), int'(e.b_par));
                chk(t, "bottom allowed", int'(b_allow), int'(e.b_al));
                chk(t, "bottom violation", int'(b_viol), int'(e.b_vi));
                chk(t, "R3 top valid", int'(t_valid), 1);
                chk(t, "top block", int'(t_blk), int'(e.t_idx));
                chk(t, "top is_param", int'(t_param), int'(e.t_par));
                chk(t, "top allowed", int'(t_allow), int'(e.t_al));
                chk(t, "top violation", int'(t_viol), int'(e.t_vi));
            end else begin
                chk("R8 R10", "idle valid/violation",
                    int'({b_valid, b_viol, t_valid, t_viol}), 0);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < BLK_CNT; i++) lk[i] = 1'b1;
        // R10: strobe and request while in reset are ignored
        repeat (2) @(negedge clk);
        lock_clr = 1'b1; lock_idx = IDX_W'(5); req_valid = 1'b1; req_op = 2'd2;
        @(negedge clk);
        lock_clr = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R4 / R10: every block locked after reset, block 5 too
        req(19'h00000, 2, "R4");
        req(19'h02800, 3, "R10");  // bottom block 5
        req(19'h14000, 2, "R4");   // main region
        req(19'h7FFFF, 3, "R4");

        // unlock every block
        for (int i = 0; i < BLK_CNT; i++) lock_op(1'b0, 1'b1, i);

        // R1 / R2: mapping, reads and programs
        req(19'h00000, 1, "R1 R2");
        req(19'h00800, 2, "R1 R2");
        req(19'h03FFF, 2, "R1 R2");
        req(19'h04000, 3, "R1 R2");
        req(19'h3C123, 2, "R1 R2");
        req(19'h7C000, 2, "R1 R2");
        req(19'h7E7FF, 3, "R1 R2");
        req(19'h7FFFF, 2, "R1 R2");

        // R6: write protect coverage
        wp_active = 1'b1;
        req(19'h00000, 2, "R6");
        req(19'h00800, 3, "R6");
        req(19'h01000, 2, "R6");
        req(19'h03800, 2, "R6");
        req(19'h7C000, 2, "R6");
        req(19'h7E800, 2, "R6");
        req(19'h7F000, 3, "R6");
        req(19'h7F800, 2, "R6");
        req(19'h20000, 1, "R6 R7");
        wp_active = 1'b0;

        // R5: set, clear, set wins
        lock_op(1'b1, 1'b0, 2);
        req(19'h01000, 2, "R5");
        req(19'h08000, 2, "R5");
        lock_op(1'b1, 1'b1, 3);
        req(19'h01800, 3, "R5");
        req(19'h0C000, 3, "R5");
        lock_op(1'b0, 1'b1, 2);
        req(19'h01000, 2, "R5");
        req(19'h08000, 3, "R5");

        // R9: out-of-range strobes do nothing
        lock_op(1'b1, 1'b0, 39);
        lock_op(1'b1, 1'b0, 63);
        req(19'h7FFFF, 2, "R9");
        req(19'h00000, 2, "R9");
        req(19'h1C000, 2, "R9");

        // R7: read and idle on locked block
        req(19'h01800, 1, "R7");
        req(19'h0C000, 0, "R7");

        // R4: mid-run reset relocks everything
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < BLK_CNT; i++) lk[i] = 1'b1;
        req(19'h08000, 2, "R4");
        req(19'h00800, 1, "R4 R7");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule